// File: doc/BRIEF.md
# Four-phase handshake pipeline controller

This block is a chain of self-timed pipeline stages, each one run by a single Muller C-element and modelled in a clocked style. A word enters on a four-phase left channel (`in_req`, `in_ack`, `in_data`) and leaves on a four-phase right channel (`out_req`, `out_ack`, `out_data`). There is no global valid/ready control. A stage moves only when its own request, and the acknowledge of the stage after it, allow the C-element to switch.

Each stage's C-element takes the incoming request and the inverted acknowledge of its successor. Its output is used twice. Sent directly, it is the acknowledge returned to the predecessor. Sent through a `DELAY`-cycle shift register, it is the request passed to the successor. That shift register stands in for the matched delay of bundled-data logic. The stage's `WIDTH`-bit register loads in the cycle the C-element output rises and holds at every other time.

Back-pressure works as follows. While the right side leaves `out_ack` low, `out_req` stays high and `out_data` stays fixed. Upstream stages fill until no C-element can rise. From then on, `in_ack` does not answer a new `in_req`. The environment must follow the four-phase order on both channels. It must not change `in_data` while `in_req` is high and not yet acknowledged.

Top module: `hs_pipe_chain`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `in_ack` and `out_req` are 0, so the chain is empty.
- R2: Each stage's C-element output switches as follows. It goes to 1 in the next cycle when its request is 1 and the successor's acknowledge is 0. It goes to 0 when its request is 0 and that acknowledge is 1. In every other case it holds.
- R3: `in_ack` rises only after a cycle in which `in_req` was 1, and falls only after a cycle in which `in_req` was 0.
- R4: With a four-phase right environment, `out_req` rises only while `out_ack` is 0 and falls only while `out_ack` is 1.
- R5: In an empty chain, `out_req` goes high `STAGES*(1+DELAY)` clock edges after `in_req` is raised.
- R6: If `out_ack` is held low, the chain accepts exactly `(STAGES+1)/2` words, counted as complete left handshakes. After that, a raised `in_req` gets no `in_ack`.
- R7: Words leave in the order they were accepted, with their values unchanged.
- R8: A stage register changes only in the cycle its C-element output rises. The word presented with `out_req` is therefore the word captured when the word was accepted.
- R9: While `out_req` stays high, `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | 1 | Left-channel request |
| in_ack | output | 1 | Left-channel acknowledge (first C-element output) |
| in_data | input | WIDTH | Left-channel word, held while the request is unacknowledged |
| out_req | output | 1 | Right-channel request (delayed last C-element output) |
| out_ack | input | 1 | Right-channel acknowledge |
| out_data | output | WIDTH | Right-channel word from the last stage register |

## Verification
The hardest state to reach from the ports is the fully stalled chain. In that state the C-elements alternate between 1 and 0 from the output end, so there is a one-stage bubble between every two held words. No further left handshake can finish. To get there, the stimulus holds `out_ack` low and offers words until an acknowledge times out, then withdraws the unanswered request. It then lets the sink drain the chain and checks the count and order of the words that come out. Random pusher gaps and random sink delays then exercise the rise and hold paths of the C-elements in mixed phases.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Next state of a C-element whose second input is inverted:
  // set when a=1 and b=0, clear when a=0 and b=1, otherwise hold.
  function automatic logic celem_next(logic q, logic a, logic b);
    if (a && !b)      return 1'b1;
    else if (!a && b) return 1'b0;
    else              return q;
  endfunction

endpackage

// File: rtl/hs_celem.sv
module hs_celem
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ack,
  output logic q,
  output logic fire
);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= celem_next(q, req, ack);
  end

  assign fire = !q && req && !ack;

  // R2: switching rule of the C-element with an inverted acknowledge input
  a_r2_rise: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> q);
  a_r2_fall: assert property (@(posedge clk) disable iff (rst)
    (!req && ack) |=> !q);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (req == ack) |=> $stable(q));

endmodule

// File: rtl/hs_req_delay.sv
module hs_req_delay #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] taps;

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else begin
      taps[0] <= d;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign q = taps[DEPTH-1];

endmodule

// File: rtl/hs_stage.sv
module hs_stage #(
  parameter int WIDTH = 8,
  parameter int DELAY = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_req,
  output logic             l_ack,
  input  logic [WIDTH-1:0] l_data,
  output logic             r_req,
  input  logic             r_ack,
  output logic [WIDTH-1:0] r_data
);

  logic c_out;
  logic c_fire;

  hs_celem u_celem (
    .clk  (clk),
    .rst  (rst),
    .req  (l_req),
    .ack  (r_ack),
    .q    (c_out),
    .fire (c_fire)
  );

  assign l_ack = c_out;

  generate
    if (DELAY == 0) begin : g_nodly
      assign r_req = c_out;
    end else begin : g_dly
      hs_req_delay #(.DEPTH(DELAY)) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (c_out),
        .q   (r_req)
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         r_data <= '0;
    else if (c_fire) r_data <= l_data;
  end

  // R8: the register only moves together with a rising C-element output
  a_r8_load_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(r_data) |-> $rose(c_out));

endmodule

// File: rtl/hs_pipe_chain.sv
module hs_pipe_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4,
  parameter int DELAY  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_req,
  output logic             in_ack,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_req,
  input  logic             out_ack,
  output logic [WIDTH-1:0] out_data
);

  localparam int NODES = STAGES + 1;

  logic             req_n  [NODES];
  logic             ack_n  [NODES];
  logic [WIDTH-1:0] data_n [NODES];

  assign req_n[0]      = in_req;
  assign data_n[0]     = in_data;
  assign in_ack        = ack_n[0];
  assign ack_n[STAGES] = out_ack;
  assign out_req       = req_n[STAGES];
  assign out_data      = data_n[STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      hs_stage #(.WIDTH(WIDTH), .DELAY(DELAY)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .l_req  (req_n[s]),
        .l_ack  (ack_n[s]),
        .l_data (data_n[s]),
        .r_req  (req_n[s+1]),
        .r_ack  (ack_n[s+1]),
        .r_data (data_n[s+1])
      );
    end
  endgenerate

  // R3: left acknowledge follows the left request
  a_r3_ack_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(in_req));
  a_r3_ack_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> !$past(in_req));
  // R4: right request waits for the right acknowledge phase
  a_r4_req_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> !$past(out_ack));
  a_r4_req_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(out_req) |-> $past(out_ack));
  // R9: offered word is steady while requested
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    (out_req && $past(out_req)) |-> $stable(out_data));

endmodule

// File: tb/sim_hs_pipe_chain.sv
module sim_hs_pipe_chain;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int K    = 4;
  localparam int D    = 1;
  localparam int FILL = (K + 1) / 2;
  localparam int LAT  = K * (1 + D);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_req = 1'b0;
  logic         in_ack;
  logic [W-1:0] in_data = '0;
  logic         out_req;
  logic         out_ack = 1'b0;
  logic [W-1:0] out_data;

  int           checks = 0;
  int           bad = 0;
  int           got = 0;
  logic [W-1:0] expq[$];
  logic         sink_on = 1'b0;
  logic         sink_rand = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_pipe_chain #(.WIDTH(W), .STAGES(K), .DELAY(D)) u0 (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Right-side environment: four-phase sink with a behavioural word queue.
  initial begin
    forever begin
      @(negedge clk);
      if (sink_on && out_req && !out_ack) begin
        int gap;
        gap = sink_rand ? int'($urandom_range(0, 5)) : 0;
        for (int i = 0; i < gap; i++) @(negedge clk);
        if (expq.size() == 0) begin
          check(1'b0, "R7", "word without acceptance", int'(out_data), -1);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(out_data == e, "R7", "word order/value", int'(out_data), int'(e));
        end
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        out_ack = 1'b0;
        got++;
      end
    end
  end

  // Per-clock protocol monitor, sampled after the edge settles.
  logic         p_ack = 1'b0, p_oreq = 1'b0;
  logic [W-1:0] p_odata = '0;
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (in_ack && !p_ack)   check(in_req == 1'b1, "R3", "in_ack rise", int'(in_req), 1);
      if (!in_ack && p_ack)   check(in_req == 1'b0, "R3", "in_ack fall", int'(in_req), 0);
      if (out_req && !p_oreq) check(out_ack == 1'b0, "R4", "out_req rise", int'(out_ack), 0);
      if (!out_req && p_oreq) check(out_ack == 1'b1, "R4", "out_req fall", int'(out_ack), 1);
      if (out_req && p_oreq)  check(out_data == p_odata, "R9", "out_data hold",
                                    int'(out_data), int'(p_odata));
    end
    p_ack = in_ack; p_oreq = out_req; p_odata = out_data;
  end

  task automatic try_push(input logic [W-1:0] w, output bit ok);
    int t;
    ok = 1'b0;
    t = 0;
    while (in_ack && t < 40) begin @(negedge clk); t++; end
    if (in_ack) return;
    in_data = w;
    in_req  = 1'b1;
    t = 0;
    while (!in_ack && t < 40) begin @(negedge clk); t++; end
    if (!in_ack) begin
      in_req = 1'b0;
      @(negedge clk);
      return;
    end
    expq.push_back(w);
    in_req = 1'b0;
    ok = 1'b1;
  endtask

  task automatic wait_got(input int target);
    int t;
    t = 0;
    while (got < target && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n, acc, base;
    bit ok;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(in_ack == 1'b0, "R1", "in_ack in reset", int'(in_ack), 0);
    check(out_req == 1'b0, "R1", "out_req in reset", int'(out_req), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ack == 1'b0, "R1", "in_ack after reset", int'(in_ack), 0);
    check(out_req == 1'b0, "R1", "out_req after reset", int'(out_req), 0);

    // R5 / R8: single word latency through an empty chain
    sink_on = 1'b1;
    in_data = 8'h5A;
    in_req  = 1'b1;
    expq.push_back(8'h5A);
    n = 0;
    while (!out_req && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (in_ack) in_req = 1'b0;
    end
    check(n == LAT, "R5", "request latency", n, LAT);
    check(out_data == 8'h5A, "R8", "captured word", int'(out_data), 8'h5A);
    wait_got(1);
    check(got == 1, "R7", "single word delivered", got, 1);

    // R6 / R2: fill with the right side stalled
    sink_on = 1'b0;
    repeat (20) @(negedge clk);
    base = got;
    acc = 0;
    for (int i = 0; i < K + 2; i++) begin
      try_push(W'(8'h10 + i), ok);
      if (ok) acc++;
    end
    check(acc == FILL, "R6", "words held under stall", acc, FILL);
    check(out_req == 1'b1, "R2", "last stage holds request", int'(out_req), 1);
    check(got == base, "R2", "nothing leaves while stalled", got, base);
    sink_on = 1'b1;
    wait_got(base + acc);
    check(got == base + FILL, "R7", "drained count", got - base, FILL);
    check(expq.size() == 0, "R7", "queue empty after drain", expq.size(), 0);

    // R7: streaming with random gaps on both sides, two rounds
    for (int round = 0; round < 2; round++) begin
      sink_rand = (round == 1);
      base = got;
      for (int i = 0; i < 24; i++) begin
        int g;
        ok = 1'b0;
        while (!ok) try_push(W'($urandom_range(0, 255)), ok);
        g = (round == 0) ? int'($urandom_range(0, 3)) : 0;
        for (int j = 0; j < g; j++) @(negedge clk);
      end
      wait_got(base + 24);
      check(got == base + 24, "R7", "stream count", got - base, 24);
    end

    repeat (10) @(negedge clk);
    check(in_ack == 1'b0 && out_req == 1'b0, "R3", "idle at end",
          int'({in_ack, out_req}), 0);
    finish_run();
  end

endmodule